// File: doc/BRIEF.md
# DMA Address and Count Sequencer

This block is the address and length engine for one DMA channel. Software, through a programming path outside this block, loads a 16-bit current address, a 16-bit transfer count and an 8-bit page value. The transfer logic then pulses `advance_i` once per transfer. For each transfer the block presents a 24-bit physical byte address and a pair of byte enables. It raises a read or write strobe that matches the selected transfer direction. After every accepted transfer the address moves up by one and the count moves down by one.

The address counter is held apart from the page value and never carries into it. A transfer that runs past the top of its region therefore wraps back to the start of the same region: 64K bytes in byte mode, or 128K bytes in word mode. The count is programmed as the number of transfers minus one. The transfer whose count passes below zero is the last one and produces a terminal-count pulse. At that point the channel either masks itself and ignores further pulses, or, with auto-reload on, restores the programmed address and count and keeps going.

Top module: `dmaseq_engine`

## Requirements
- R1: In byte mode (`word_mode_i`=0), `phys_addr_o` equals {page value, current address}: the page supplies bits 23:16 and the address counter supplies bits 15:0.
- R2: In word mode (`word_mode_i`=1), `phys_addr_o` equals {page bits 7:1, current address, 1'b0}: the address counter supplies bits 16:1, bit 0 is 0, and page bit 0 has no effect on the output.
- R3: In word mode `byte_en_o` is 2'b11. In byte mode exactly one enable is set: 2'b01 when address bit 0 is 0 and 2'b10 when it is 1.
- R4: Each accepted advance pulse increases the current address by 1 and decreases the count by 1, both seen on the outputs after the clock edge. An address of FFFFh wraps to 0000h and the page value is left unchanged.
- R5: `tc_o` is high during an accepted advance pulse exactly when the count is 0000h (the count then becomes FFFFh), and low at all other times.
- R6: After terminal count with `auto_init_i`=0, `masked_o` is 1. While masked, advance pulses change neither the address nor the count and raise no strobe and no `tc_o`. A pulse on `mask_clr_i` returns `masked_o` to 0.
- R7: With `auto_init_i`=1, terminal count reloads the address and count last loaded by software in place of stepping, and `masked_o` stays 0.
- R8: During an accepted advance, `xfer_type_i`=2'b01 (to memory) raises only `mem_wr_o`, and 2'b10 (from memory) raises only `mem_rd_o`. 2'b00 (verify) and 2'b11 raise neither strobe but still step the address and count.
- R9: After reset the address, count and page are 0, `masked_o` is 0, and `tc_o`, `mem_rd_o` and `mem_wr_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_addr_i | input | 1 | Load current and reload address from `addr_val_i` |
| addr_val_i | input | 16 | Address value to load |
| load_cnt_i | input | 1 | Load current and reload count from `cnt_val_i` |
| cnt_val_i | input | 16 | Count value to load (transfers minus one) |
| load_page_i | input | 1 | Load the page value from `page_val_i` |
| page_val_i | input | 8 | Page value to load |
| word_mode_i | input | 1 | 1 = 16-bit transfers, 0 = byte transfers |
| auto_init_i | input | 1 | 1 = reload address and count at terminal count |
| xfer_type_i | input | 2 | 00 verify, 01 to memory, 10 from memory, 11 treated as verify |
| mask_clr_i | input | 1 | Clear the channel mask |
| advance_i | input | 1 | One-cycle pulse per transfer |
| phys_addr_o | output | 24 | Physical byte address of the current transfer |
| byte_en_o | output | 2 | Byte lanes in use |
| cnt_o | output | 16 | Current remaining count |
| tc_o | output | 1 | Terminal count, high with the last accepted advance |
| mem_rd_o | output | 1 | Memory read strobe for the current transfer |
| mem_wr_o | output | 1 | Memory write strobe for the current transfer |
| masked_o | output | 1 | Channel masked, advances ignored |

## Verification
The hardest situation to reach is the end of a transfer that also wraps the address while the page must not move. It needs the address near FFFFh and the count near zero at the same moment. The stimulus gets there by loading an address two below the top of the region together with a count of 3. Four pulses then carry the address across the wrap and reach terminal count on the last one. One more pulse shows that the channel stays masked. The auto-reload case is reached by loading a count of 1 and watching the programmed values return on the second pulse. Word-mode wrap is checked from an address of FFFFh with an odd page value.

// File: rtl/dmaseq_pkg.sv
package dmaseq_pkg;

   typedef enum logic [1:0] {
      XFER_VERIFY    = 2'b00,
      XFER_TO_MEM    = 2'b01,
      XFER_FROM_MEM  = 2'b10,
      XFER_RESERVED  = 2'b11
   } xfer_kind_e;

   localparam int unsigned LANES = 2;

   localparam logic [LANES-1:0] LANES_ALL  = 2'b11;
   localparam logic [LANES-1:0] LANE_EVEN  = 2'b01;
   localparam logic [LANES-1:0] LANE_ODD   = 2'b10;

endpackage

// File: rtl/dmaseq_addr_ctr.sv
module dmaseq_addr_ctr #(
   parameter int unsigned W = 16
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         load_i,
   input  logic [W-1:0] load_val_i,
   input  logic         step_i,
   input  logic         reload_i,
   output logic [W-1:0] cur_o
);

   logic [W-1:0] base_q;
   logic [W-1:0] cur_q;
   logic [W-1:0] cur_inc;

   // the increment is W bits wide, so it drops any carry and never reaches the page
   assign cur_inc = cur_q + {{(W-1){1'b0}}, 1'b1};

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         base_q <= '0;
         cur_q  <= '0;
      end else if (load_i) begin
         base_q <= load_val_i;
         cur_q  <= load_val_i;
      end else if (reload_i) begin
         cur_q  <= base_q;
      end else if (step_i) begin
         cur_q  <= cur_inc;
      end
   end

   assign cur_o = cur_q;

endmodule

// File: rtl/dmaseq_cnt_ctr.sv
module dmaseq_cnt_ctr #(
   parameter int unsigned W = 16
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         load_i,
   input  logic [W-1:0] load_val_i,
   input  logic         step_i,
   input  logic         reload_i,
   output logic [W-1:0] cur_o,
   output logic         zero_o
);

   logic [W-1:0] base_q;
   logic [W-1:0] cur_q;
   logic [W-1:0] cur_dec;

   assign cur_dec = cur_q - {{(W-1){1'b0}}, 1'b1};

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         base_q <= '0;
         cur_q  <= '0;
      end else if (load_i) begin
         base_q <= load_val_i;
         cur_q  <= load_val_i;
      end else if (reload_i) begin
         cur_q  <= base_q;
      end else if (step_i) begin
         cur_q  <= cur_dec;
      end
   end

   assign cur_o  = cur_q;
   assign zero_o = (cur_q == '0);

endmodule

// File: rtl/dmaseq_map.sv
module dmaseq_map
   import dmaseq_pkg::*;
#(
   parameter int unsigned ADDR_W  = 16,
   parameter int unsigned PAGE_W  = 8,
   parameter bit          WORD_EN = 1'b1,
   localparam int unsigned PHYS_W = ADDR_W + PAGE_W
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [PAGE_W-1:0] page_i,
   input  logic              word_mode_i,
   output logic [PHYS_W-1:0] phys_o,
   output logic [LANES-1:0]  lanes_o
);

   logic [PHYS_W-1:0] byte_phys;
   logic [LANES-1:0]  byte_lanes;

   assign byte_phys  = {page_i, addr_i};
   assign byte_lanes = addr_i[0] ? LANE_ODD : LANE_EVEN;

   generate
      if (WORD_EN) begin : g_word
         logic [PHYS_W-1:0] word_phys;
         // the counter moves up one bit, the low page bit drops out
         assign word_phys = {page_i[PAGE_W-1:1], addr_i, 1'b0};
         assign phys_o  = word_mode_i ? word_phys : byte_phys;
         assign lanes_o = word_mode_i ? LANES_ALL : byte_lanes;
      end else begin : g_byte_only
         assign phys_o  = byte_phys;
         assign lanes_o = byte_lanes;
      end
   endgenerate

endmodule

// File: rtl/dmaseq_ctl.sv
module dmaseq_ctl
   import dmaseq_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       advance_i,
   input  logic       cnt_zero_i,
   input  logic       auto_init_i,
   input  logic       mask_clr_i,
   input  logic [1:0] xfer_type_i,
   output logic       step_o,
   output logic       reload_o,
   output logic       tc_o,
   output logic       rd_o,
   output logic       wr_o,
   output logic       masked_o
);

   logic       mask_q;
   logic       accept;
   logic       tc;
   xfer_kind_e kind;

   assign kind     = xfer_kind_e'(xfer_type_i);
   assign accept   = advance_i & ~mask_q;
   assign tc       = accept & cnt_zero_i;
   assign reload_o = tc & auto_init_i;
   assign step_o   = accept & ~reload_o;
   assign tc_o     = tc;

   always_comb begin
      rd_o = 1'b0;
      wr_o = 1'b0;
      unique case (kind)
         XFER_TO_MEM:   wr_o = accept;
         XFER_FROM_MEM: rd_o = accept;
         default: begin
            rd_o = 1'b0;
            wr_o = 1'b0;
         end
      endcase
   end

   // terminal count without reload wins over a clear in the same cycle
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mask_q <= 1'b0;
      end else if (tc && !auto_init_i) begin
         mask_q <= 1'b1;
      end else if (mask_clr_i) begin
         mask_q <= 1'b0;
      end
   end

   assign masked_o = mask_q;

endmodule

// File: rtl/dmaseq_engine.sv
module dmaseq_engine
   import dmaseq_pkg::*;
#(
   parameter int unsigned ADDR_W  = 16,
   parameter int unsigned CNT_W   = 16,
   parameter int unsigned PAGE_W  = 8,
   parameter bit          WORD_EN = 1'b1,
   localparam int unsigned PHYS_W = ADDR_W + PAGE_W
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              load_addr_i,
   input  logic [ADDR_W-1:0] addr_val_i,
   input  logic              load_cnt_i,
   input  logic [CNT_W-1:0]  cnt_val_i,
   input  logic              load_page_i,
   input  logic [PAGE_W-1:0] page_val_i,
   input  logic              word_mode_i,
   input  logic              auto_init_i,
   input  logic [1:0]        xfer_type_i,
   input  logic              mask_clr_i,
   input  logic              advance_i,
   output logic [PHYS_W-1:0] phys_addr_o,
   output logic [LANES-1:0]  byte_en_o,
   output logic [CNT_W-1:0]  cnt_o,
   output logic              tc_o,
   output logic              mem_rd_o,
   output logic              mem_wr_o,
   output logic              masked_o
);

   generate
      if (ADDR_W < 2) begin : g_bad_addr_w
         $error("dmaseq_engine: ADDR_W must be at least 2");
      end
      if (CNT_W < 1) begin : g_bad_cnt_w
         $error("dmaseq_engine: CNT_W must be at least 1");
      end
      if (PAGE_W < 2) begin : g_bad_page_w
         $error("dmaseq_engine: PAGE_W must be at least 2");
      end
   endgenerate

   logic [ADDR_W-1:0] addr_cur;
   logic [PAGE_W-1:0] page_q;
   logic              cnt_zero;
   logic              step;
   logic              reload;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         page_q <= '0;
      end else if (load_page_i) begin
         page_q <= page_val_i;
      end
   end

   dmaseq_ctl u_ctl (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .advance_i   (advance_i),
      .cnt_zero_i  (cnt_zero),
      .auto_init_i (auto_init_i),
      .mask_clr_i  (mask_clr_i),
      .xfer_type_i (xfer_type_i),
      .step_o      (step),
      .reload_o    (reload),
      .tc_o        (tc_o),
      .rd_o        (mem_rd_o),
      .wr_o        (mem_wr_o),
      .masked_o    (masked_o)
   );

   dmaseq_addr_ctr #(.W(ADDR_W)) u_addr (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (load_addr_i),
      .load_val_i (addr_val_i),
      .step_i     (step),
      .reload_i   (reload),
      .cur_o      (addr_cur)
   );

   dmaseq_cnt_ctr #(.W(CNT_W)) u_cnt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (load_cnt_i),
      .load_val_i (cnt_val_i),
      .step_i     (step),
      .reload_i   (reload),
      .cur_o      (cnt_o),
      .zero_o     (cnt_zero)
   );

   dmaseq_map #(
      .ADDR_W  (ADDR_W),
      .PAGE_W  (PAGE_W),
      .WORD_EN (WORD_EN)
   ) u_map (
      .addr_i      (addr_cur),
      .page_i      (page_q),
      .word_mode_i (word_mode_i),
      .phys_o      (phys_addr_o),
      .lanes_o     (byte_en_o)
   );

endmodule

// File: rtl/dmaseq_engine_chk.sv
module dmaseq_engine_chk #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned PHYS_W = 24
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              load_addr_i,
   input logic              load_cnt_i,
   input logic              load_page_i,
   input logic              word_mode_i,
   input logic              auto_init_i,
   input logic [1:0]        xfer_type_i,
   input logic              mask_clr_i,
   input logic              advance_i,
   input logic [ADDR_W-1:0] addr_cur,
   input logic [PHYS_W-1:0] phys_addr_o,
   input logic [1:0]        byte_en_o,
   input logic [CNT_W-1:0]  cnt_o,
   input logic              tc_o,
   input logic              mem_rd_o,
   input logic              mem_wr_o,
   input logic              masked_o
);

   logic accepted;
   assign accepted = advance_i && !masked_o;

   assert_lanes_word_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      word_mode_i |-> (byte_en_o == 2'b11) && (phys_addr_o[0] == 1'b0));

   assert_lanes_byte_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !word_mode_i |-> ($countones(byte_en_o) == 1) && (byte_en_o[1] == phys_addr_o[0]));

   assert_addr_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (accepted && !load_addr_i && !(tc_o && auto_init_i))
         |=> addr_cur == $past(addr_cur) + 1'b1);

   assert_cnt_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (accepted && !load_cnt_i && !(tc_o && auto_init_i))
         |=> cnt_o == $past(cnt_o) - 1'b1);

   assert_tc_at_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tc_o |-> (cnt_o == '0) && advance_i);

   assert_tc_masks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tc_o && !auto_init_i) |=> masked_o);

   assert_masked_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      masked_o |-> !tc_o && !mem_rd_o && !mem_wr_o);

   assert_masked_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (masked_o && !load_addr_i && !load_cnt_i && !load_page_i)
         |=> $stable(cnt_o) && $stable(addr_cur));

   assert_reload_unmasked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tc_o && auto_init_i && !masked_o) |=> !masked_o);

   assert_verify_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (xfer_type_i[0] == xfer_type_i[1]) |-> !mem_rd_o && !mem_wr_o);

   assert_one_strobe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({mem_rd_o, mem_wr_o}));

endmodule

bind dmaseq_engine dmaseq_engine_chk #(
   .ADDR_W (ADDR_W),
   .CNT_W  (CNT_W),
   .PHYS_W (PHYS_W)
) chk_i (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .load_addr_i (load_addr_i),
   .load_cnt_i  (load_cnt_i),
   .load_page_i (load_page_i),
   .word_mode_i (word_mode_i),
   .auto_init_i (auto_init_i),
   .xfer_type_i (xfer_type_i),
   .mask_clr_i  (mask_clr_i),
   .advance_i   (advance_i),
   .addr_cur    (addr_cur),
   .phys_addr_o (phys_addr_o),
   .byte_en_o   (byte_en_o),
   .cnt_o       (cnt_o),
   .tc_o        (tc_o),
   .mem_rd_o    (mem_rd_o),
   .mem_wr_o    (mem_wr_o),
   .masked_o    (masked_o)
);

// File: tb/dmaseq_engine_tb_top.sv
`timescale 1ns/1ps
module dmaseq_engine_tb_top;

   logic        clk_i = 1'b0;
   logic        rst_ni = 1'b0;
   logic        load_addr_i = 1'b0;
   logic [15:0] addr_val_i = '0;
   logic        load_cnt_i = 1'b0;
   logic [15:0] cnt_val_i = '0;
   logic        load_page_i = 1'b0;
   logic [7:0]  page_val_i = '0;
   logic        word_mode_i = 1'b0;
   logic        auto_init_i = 1'b0;
   logic [1:0]  xfer_type_i = 2'b00;
   logic        mask_clr_i = 1'b0;
   logic        advance_i = 1'b0;
   logic [23:0] phys_addr_o;
   logic [1:0]  byte_en_o;
   logic [15:0] cnt_o;
   logic        tc_o;
   logic        mem_rd_o;
   logic        mem_wr_o;
   logic        masked_o;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2.5 clk_i = ~clk_i;

   dmaseq_engine dut_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .load_addr_i (load_addr_i),
      .addr_val_i  (addr_val_i),
      .load_cnt_i  (load_cnt_i),
      .cnt_val_i   (cnt_val_i),
      .load_page_i (load_page_i),
      .page_val_i  (page_val_i),
      .word_mode_i (word_mode_i),
      .auto_init_i (auto_init_i),
      .xfer_type_i (xfer_type_i),
      .mask_clr_i  (mask_clr_i),
      .advance_i   (advance_i),
      .phys_addr_o (phys_addr_o),
      .byte_en_o   (byte_en_o),
      .cnt_o       (cnt_o),
      .tc_o        (tc_o),
      .mem_rd_o    (mem_rd_o),
      .mem_wr_o    (mem_wr_o),
      .masked_o    (masked_o)
   );

   // {word, page[7:0], addr[15:0], expected phys[23:0], expected lanes[1:0]}
   localparam int NVEC = 7;
   localparam logic [50:0] VEC [NVEC] = '{
      {1'b0, 8'h12, 16'h3456, 24'h123456, 2'b01},
      {1'b0, 8'h12, 16'h3457, 24'h123457, 2'b10},
      {1'b0, 8'hAB, 16'h0000, 24'hAB0000, 2'b01},
      {1'b1, 8'h12, 16'h3456, 24'h1268AC, 2'b11},
      {1'b1, 8'h13, 16'h3456, 24'h1268AC, 2'b11},
      {1'b1, 8'hFF, 16'hFFFF, 24'hFFFFFE, 2'b11},
      {1'b1, 8'h00, 16'h8000, 24'h010000, 2'b11}
   };

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic load_all(input logic [7:0] pg, input logic [15:0] ad,
                           input logic [15:0] ct);
      @(negedge clk_i);
      load_page_i = 1'b1; page_val_i = pg;
      load_addr_i = 1'b1; addr_val_i = ad;
      load_cnt_i  = 1'b1; cnt_val_i  = ct;
      @(negedge clk_i);
      load_page_i = 1'b0; load_addr_i = 1'b0; load_cnt_i = 1'b0;
      #1;
   endtask

   // pulses advance for one cycle; samples the same-cycle outputs
   task automatic adv(output logic tc, output logic rd, output logic wr);
      @(negedge clk_i);
      advance_i = 1'b1;
      #1;
      tc = tc_o; rd = mem_rd_o; wr = mem_wr_o;
      @(negedge clk_i);
      advance_i = 1'b0;
      #1;
   endtask

   task automatic clear_mask();
      @(negedge clk_i);
      mask_clr_i = 1'b1;
      @(negedge clk_i);
      mask_clr_i = 1'b0;
      #1;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic tc, rd, wr;
      repeat (3) @(negedge clk_i);
      #1;
      // R9 reset state
      check("R9", "phys", 32'(phys_addr_o), 32'h0);
      check("R9", "count", 32'(cnt_o), 32'h0);
      check("R9", "masked", 32'(masked_o), 32'h0);
      check("R9", "strobes", {29'h0, tc_o, mem_rd_o, mem_wr_o}, 32'h0);
      rst_ni = 1'b1;

      // table walk: R1, R2, R3 address map and lanes
      for (int i = 0; i < NVEC; i++) begin
         word_mode_i = VEC[i][50];
         load_all(VEC[i][49:42], VEC[i][41:26], 16'h0000);
         check(VEC[i][50] ? "R2" : "R1", "phys", 32'(phys_addr_o), 32'(VEC[i][25:2]));
         check("R3", "lanes", 32'(byte_en_o), 32'(VEC[i][1:0]));
      end

      // wrap and terminal count in byte mode, to-memory transfers
      word_mode_i = 1'b0; auto_init_i = 1'b0; xfer_type_i = 2'b01;
      load_all(8'h12, 16'hFFFE, 16'd3);
      adv(tc, rd, wr);
      check("R8", "wr strobe", {30'h0, rd, wr}, 32'h1);
      check("R5", "tc early", 32'(tc), 32'h0);
      check("R4", "phys step", 32'(phys_addr_o), 32'h12FFFF);
      check("R4", "count step", 32'(cnt_o), 32'd2);
      adv(tc, rd, wr);
      check("R4", "phys wrap", 32'(phys_addr_o), 32'h120000);
      adv(tc, rd, wr);
      check("R4", "count", 32'(cnt_o), 32'd0);
      check("R5", "tc not yet", 32'(tc), 32'h0);
      adv(tc, rd, wr);
      check("R5", "tc at zero", 32'(tc), 32'h1);
      check("R5", "count roll", 32'(cnt_o), 32'hFFFF);
      check("R6", "masked", 32'(masked_o), 32'h1);
      check("R4", "phys", 32'(phys_addr_o), 32'h120002);
      // R6 masked channel ignores advance
      adv(tc, rd, wr);
      check("R6", "masked outputs", {29'h0, tc, rd, wr}, 32'h0);
      check("R6", "phys held", 32'(phys_addr_o), 32'h120002);
      check("R6", "count held", 32'(cnt_o), 32'hFFFF);
      clear_mask();
      check("R6", "mask cleared", 32'(masked_o), 32'h0);

      // R8 verify steps without strobes
      xfer_type_i = 2'b00;
      adv(tc, rd, wr);
      check("R8", "verify strobes", {30'h0, rd, wr}, 32'h0);
      check("R8", "verify phys", 32'(phys_addr_o), 32'h120003);
      check("R8", "verify count", 32'(cnt_o), 32'hFFFE);
      xfer_type_i = 2'b10;
      adv(tc, rd, wr);
      check("R8", "rd strobe", {30'h0, rd, wr}, 32'h2);
      xfer_type_i = 2'b11;
      adv(tc, rd, wr);
      check("R8", "reserved strobes", {30'h0, rd, wr}, 32'h0);

      // R7 auto reload
      xfer_type_i = 2'b01; auto_init_i = 1'b1;
      load_all(8'h12, 16'h0100, 16'd1);
      adv(tc, rd, wr);
      check("R7", "first step", 32'(phys_addr_o), 32'h120101);
      adv(tc, rd, wr);
      check("R7", "tc", 32'(tc), 32'h1);
      check("R7", "phys reloaded", 32'(phys_addr_o), 32'h120100);
      check("R7", "count reloaded", 32'(cnt_o), 32'd1);
      check("R7", "not masked", 32'(masked_o), 32'h0);
      auto_init_i = 1'b0;

      // R2/R4 word mode wrap stays inside the 128K region, page bit 0 unused
      word_mode_i = 1'b1;
      load_all(8'h13, 16'hFFFF, 16'd5);
      check("R2", "word top", 32'(phys_addr_o), 32'h13FFFE);
      adv(tc, rd, wr);
      check("R4", "word wrap", 32'(phys_addr_o), 32'h120000);
      check("R3", "word lanes", 32'(byte_en_o), 32'h3);
      check("R4", "word count", 32'(cnt_o), 32'd4);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule